// File: doc/BRIEF.md
# Two-Level Masked Interrupt Status Unit

This block gathers six single-cycle event pulses from a data processing engine and turns them into a readable status word and one interrupt line. Two masks sit between the events and the line. The status-enable mask decides which events are recorded in the status register. The signal-enable mask decides which recorded bits may raise the line. An event can therefore be kept for polling while the line stays quiet.

Software reaches the three registers over a plain register bus with an address, write data, a write strobe and a combinational read-data return. It clears recorded events by writing ones to the status word. The line is driven by a two-state machine. In state LINE_IDLE the line is low. It moves to LINE_RAISED (transition RAISE) when any recorded bit is also signal-enabled. It returns to LINE_IDLE (transition DROP) when no such bit is left. Otherwise it stays where it is (HOLD).

Top module: `evt_irq_unit`

## Requirements
- R1: Register offsets are 0x04 for status, 0x08 for status-enable and 0x0C for signal-enable. Event input i maps to bit i. The bits are 0 transfer done, 1 main-area DMA done, 2 spare-area DMA done, 3 ECC error, 4 moved to spare area and 5 moved to main area.
- R2: A pulse on an event whose status-enable bit is 1 sets its status bit at the next clock edge. The bit then stays set until it is cleared.
- R3: A pulse on an event whose status-enable bit is 0 is ignored and leaves its status bit at 0.
- R4: A write to offset 0x04 clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R5: When an enabled event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R6: The interrupt output is registered. After each clock edge it equals the OR over all bits of (status AND signal-enable) as they stood before that edge.
- R7: Writing 0 to the signal-enable register brings the line low one cycle after that write takes effect, even while status bits stay set. Polling still shows transfer done set.
- R8: Reset clears all three registers and drives the interrupt output low.
- R9: Bits 31 to 6 of every register read as 0, and writes to those bits are ignored.
- R10: Both mask registers read back the low six bits last written to them. Reads of any other offset return 0, and writes to any other offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| evt_pulse | input | 6 | One-cycle event pulses, bit i is event i |
| irq_out | output | 1 | Registered interrupt line |

## Verification
The hardest case to reach is a clearing write and an event on the same bit in the same cycle. The stimulus drives a write of ones to the status offset together with a pulse on one of those bits, while another bit is cleared without a pulse. The second hard case is recorded status with the line masked off. The bench sets transfer done while it is signal-enabled, writes zero to signal-enable, and then polls status cycle by cycle while the line must already be low. A behavioural model in the bench predicts the read data and the line on every clock.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int EVT_COUNT   = 6;
    localparam int BUS_DATA_W  = 32;
    localparam int BUS_ADDR_W  = 8;

    localparam int OFS_STATUS  = 'h04;
    localparam int OFS_STS_EN  = 'h08;
    localparam int OFS_SIG_EN  = 'h0C;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_STS_EN = 2'd2,
        SEL_SIG_EN = 2'd3
    } reg_sel_e;

    typedef enum logic {
        LINE_IDLE   = 1'b0,
        LINE_RAISED = 1'b1
    } line_state_e;

endpackage

// File: rtl/evt_irq_regdec.sv
module evt_irq_regdec
    import evt_irq_pkg::*;
#(
    parameter int ADDR_W = BUS_ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_STS_EN = ADDR_W'(OFS_STS_EN);
    localparam logic [ADDR_W-1:0] A_SIG_EN = ADDR_W'(OFS_SIG_EN);

    always_comb begin
        case (addr)
            A_STATUS: sel = SEL_STATUS;
            A_STS_EN: sel = SEL_STS_EN;
            A_SIG_EN: sel = SEL_SIG_EN;
            default:  sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/evt_irq_mask_reg.sv
module evt_irq_mask_reg #(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr) begin
            q <= wdata;
        end
    end
endmodule

// File: rtl/evt_irq_status_bank.sv
module evt_irq_status_bank #(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] evt,
    input  logic [WIDTH-1:0] latch_en,
    input  logic [WIDTH-1:0] clr,
    output logic [WIDTH-1:0] sts
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic set_b;
        assign set_b = evt[b] & latch_en[b];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sts[b] <= 1'b0;
            end else if (set_b) begin
                // a new event takes priority over a same-cycle clear
                sts[b] <= 1'b1;
            end else if (clr[b]) begin
                sts[b] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/evt_irq_line_fsm.sv
module evt_irq_line_fsm
    import evt_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic irq
);
    line_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LINE_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_IDLE:   if (pending)  state_d = LINE_RAISED;
            LINE_RAISED: if (!pending) state_d = LINE_IDLE;
            default:     state_d = LINE_IDLE;
        endcase
    end

    always_comb begin
        irq = (state_q == LINE_RAISED);
    end
endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
    import evt_irq_pkg::*;
#(
    parameter int NUM_EVT = EVT_COUNT,
    parameter int DATA_W  = BUS_DATA_W,
    parameter int ADDR_W  = BUS_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_EVT-1:0] evt_pulse,
    output logic              irq_out
);
    reg_sel_e           sel;
    logic [NUM_EVT-1:0] wr_bits;
    logic [NUM_EVT-1:0] sts_q;
    logic [NUM_EVT-1:0] sten_q;
    logic [NUM_EVT-1:0] sgen_q;
    logic [NUM_EVT-1:0] clr_bits;
    logic               wr_sten;
    logic               wr_sgen;
    logic               pending;

    assign wr_bits = bus_wdata[NUM_EVT-1:0];

    evt_irq_regdec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign wr_sten  = bus_we && (sel == SEL_STS_EN);
    assign wr_sgen  = bus_we && (sel == SEL_SIG_EN);
    assign clr_bits = (bus_we && (sel == SEL_STATUS)) ? wr_bits : '0;

    evt_irq_mask_reg #(.WIDTH(NUM_EVT)) u_sten (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_sten),
        .wdata (wr_bits),
        .q     (sten_q)
    );

    evt_irq_mask_reg #(.WIDTH(NUM_EVT)) u_sgen (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_sgen),
        .wdata (wr_bits),
        .q     (sgen_q)
    );

    evt_irq_status_bank #(.WIDTH(NUM_EVT)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_pulse),
        .latch_en (sten_q),
        .clr      (clr_bits),
        .sts      (sts_q)
    );

    assign pending = |(sts_q & sgen_q);

    evt_irq_line_fsm u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .irq     (irq_out)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_STATUS: bus_rdata[NUM_EVT-1:0] = sts_q;
            SEL_STS_EN: bus_rdata[NUM_EVT-1:0] = sten_q;
            SEL_SIG_EN: bus_rdata[NUM_EVT-1:0] = sgen_q;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/evt_irq_unit_chk.sv
module evt_irq_unit_chk
    import evt_irq_pkg::*;
#(
    parameter int NUM_EVT = EVT_COUNT,
    parameter int DATA_W  = BUS_DATA_W,
    parameter int ADDR_W  = BUS_ADDR_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               bus_we,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NUM_EVT-1:0] evt_pulse,
    input logic               irq_out,
    input logic [NUM_EVT-1:0] sts_q,
    input logic [NUM_EVT-1:0] sten_q,
    input logic [NUM_EVT-1:0] sgen_q
);
    localparam logic [ADDR_W-1:0] A_SIG = ADDR_W'(OFS_SIG_EN);

    AST_LINE_FOLLOWS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == $past(|(sts_q & sgen_q)))); // R6

    AST_ENABLED_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(evt_pulse & sten_q) & ~sts_q) == '0)); // R5

    AST_MASKED_EVENT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(evt_pulse & sten_q)) == '0)); // R3

    AST_SIG_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_SIG && bus_wdata[NUM_EVT-1:0] == '0) |=> ##1 !irq_out); // R7

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NUM_EVT] == '0); // R9

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (sts_q == '0 && sten_q == '0 && !irq_out)); // R8
endmodule

bind evt_irq_unit evt_irq_unit_chk #(
    .NUM_EVT (NUM_EVT),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .evt_pulse (evt_pulse),
    .irq_out   (irq_out),
    .sts_q     (sts_q),
    .sten_q    (sten_q),
    .sgen_q    (sgen_q)
);

// File: tb/evt_irq_unit_bench.sv
module evt_irq_unit_bench;
    localparam int N  = 6;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam logic [AW-1:0] A_STS  = 8'h04;
    localparam logic [AW-1:0] A_SEN  = 8'h08;
    localparam logic [AW-1:0] A_SGN  = 8'h0C;
    localparam logic [AW-1:0] A_NONE = 8'h10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = A_STS;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic [DW-1:0] bus_rdata;
    logic [N-1:0]  evt_pulse = '0;
    logic          irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // behavioural reference state
    logic [N-1:0] m_sts = '0, m_sen = '0, m_sgn = '0;
    logic         m_irq = 1'b0;

    always #2.5 clk = ~clk;

    evt_irq_unit u_evt_irq_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .evt_pulse (evt_pulse),
        .irq_out   (irq_out)
    );

    function automatic logic [DW-1:0] model_read(logic [AW-1:0] a);
        logic [DW-1:0] r = '0;
        if (a == A_STS) r[N-1:0] = m_sts;
        else if (a == A_SEN) r[N-1:0] = m_sen;
        else if (a == A_SGN) r[N-1:0] = m_sgn;
        return r;
    endfunction

    task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [N-1:0] ev, input string tag);
        logic [N-1:0] clr;
        bus_we = we; bus_addr = a; bus_wdata = d; evt_pulse = ev;
        @(posedge clk);
        if (rst_n) begin
            clr   = (we && a == A_STS) ? d[N-1:0] : '0;
            m_irq = |(m_sts & m_sgn);
            m_sts = (m_sts & ~clr) | (ev & m_sen);
            if (we && a == A_SEN) m_sen = d[N-1:0];
            if (we && a == A_SGN) m_sgn = d[N-1:0];
        end
        @(negedge clk);
        chk(bus_rdata, model_read(a), tag);
        chk({31'd0, irq_out}, {31'd0, m_irq}, "R6");
    endtask

    task automatic poll(input logic [AW-1:0] a, input string tag);
        cyc(1'b0, a, '0, '0, tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        m_sts = '0; m_sen = '0; m_sgn = '0; m_irq = 1'b0;
        poll(A_STS, "R8");
        poll(A_SEN, "R8");
        poll(A_SGN, "R8");
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        poll(A_STS, "R8");

        // R1 R2: every event latched into its own bit
        cyc(1'b1, A_SEN, 32'h0000_003F, '0, "R10");
        cyc(1'b1, A_SGN, 32'h0000_0001, '0, "R10");
        poll(A_STS, "R1");
        for (int i = 0; i < N; i++) begin
            cyc(1'b0, A_STS, '0, N'(1) << i, "R1");
            poll(A_STS, "R2");
            cyc(1'b1, A_STS, 32'h0000_003F, '0, "R4");
            poll(A_STS, "R4");
        end

        // R3: masked events ignored
        cyc(1'b1, A_SEN, 32'h0000_0015, '0, "R10");
        cyc(1'b0, A_STS, '0, 6'h2A, "R3");
        poll(A_STS, "R3");
        cyc(1'b0, A_STS, '0, 6'h3F, "R3");
        poll(A_STS, "R3");

        // R4: partial write-one-to-clear
        cyc(1'b1, A_STS, 32'h0000_0004, '0, "R4");
        poll(A_STS, "R4");
        cyc(1'b1, A_SEN, 32'h0000_003F, '0, "R10");
        cyc(1'b0, A_STS, '0, 6'h3F, "R2");
        cyc(1'b1, A_STS, 32'h0000_0005, '0, "R4");
        poll(A_STS, "R4");

        // R5: event and clear of the same bit in one cycle
        cyc(1'b1, A_STS, 32'h0000_000A, 6'h08, "R5");
        poll(A_STS, "R5");
        cyc(1'b1, A_STS, 32'h0000_003F, '0, "R4");

        // R6 R7: line with and without signal-enable
        cyc(1'b1, A_SGN, 32'h0000_0021, '0, "R10");
        cyc(1'b0, A_STS, '0, 6'h01, "R6");
        poll(A_STS, "R6");
        poll(A_STS, "R6");
        cyc(1'b1, A_SGN, 32'h0000_0000, '0, "R7");
        poll(A_STS, "R7");
        poll(A_STS, "R7");
        cyc(1'b0, A_STS, '0, 6'h20, "R7");
        poll(A_STS, "R7");
        cyc(1'b1, A_SGN, 32'h0000_0020, '0, "R6");
        poll(A_STS, "R6");
        cyc(1'b1, A_STS, 32'h0000_0020, '0, "R6");
        poll(A_STS, "R6");
        poll(A_STS, "R6");

        // R9 R10: upper bits and unused offsets
        cyc(1'b1, A_SEN, 32'hFFFF_FFC0, '0, "R9");
        poll(A_SEN, "R9");
        cyc(1'b1, A_SGN, 32'hFFFF_FFFF, '0, "R9");
        poll(A_SGN, "R9");
        cyc(1'b1, A_SEN, 32'hFFFF_FFFF, '0, "R9");
        cyc(1'b0, A_STS, '0, 6'h3F, "R2");
        poll(A_STS, "R9");
        cyc(1'b1, A_NONE, 32'hFFFF_FFFF, '0, "R10");
        poll(A_NONE, "R10");
        poll(A_SEN, "R10");
        poll(A_SGN, "R10");
        poll(A_STS, "R10");
        cyc(1'b1, 8'h00, 32'h0000_003F, '0, "R10");
        poll(A_STS, "R10");

        // R8: reset while status and line are active
        do_reset();
        poll(A_STS, "R8");
        poll(A_SGN, "R8");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule